// File: doc/BRIEF.md
# Relocatable Memory Map Decoder

This block turns a 16-bit processor address into exactly one region select: internal RAM, the control register block, a 512-byte EEPROM window, or external memory. The placement of RAM and of the register block comes from an 8-bit mapping register. Its upper nibble is the 4 KB page of RAM and its lower nibble is the 4 KB page of the register block. The EEPROM window sits in the top 512 bytes of a page chosen by a configuration nibble, and software cannot move it.

The mapping register comes out of reset with the value 0x01. Boot code may write it once, and only during a short window that follows reset. After the first write, or once the window has closed, the register is read-only. The configuration inputs can be read back as one byte. When two regions cover the same address, a fixed priority picks one, and an address that no internal region claims goes to external memory.

Top module: `memmap_decoder`

## Requirements
- R1: A synchronous reset, `rst_n` low at a clock edge, sets the mapping register to 0x01. After reset, RAM begins at 0x0000 and the register block begins at 0x1000.
- R2: Mapping bits 7:4 give the RAM page and bits 3:0 give the register page. RAM covers page offsets 0 to RAM_BYTES-1 and the register block covers offsets 0 to REG_BYTES-1. Offsets at or above these limits are not claimed by that region.
- R3: A write to the mapping register takes effect at the next edge when `acc_sel` = 2'b01, `bus_we` = 1, and the edge is one of the first 64 edges after reset is released (edge index 0 to 63).
- R4: A write attempted at edge 64 or later leaves the mapping register unchanged.
- R5: Only one write is accepted after each reset. A second write inside the window is ignored.
- R6: When the EEPROM is enabled, it occupies addresses P E00 to P FFF, where P is `cfg_ee_page`.
- R7: When `cfg_ee_en` = 0 and `cfg_single_chip` = 0, the EEPROM is absent and those addresses go to external memory.
- R8: When `cfg_single_chip` = 1, the EEPROM is present whatever `cfg_ee_en` says.
- R9: When regions overlap, the register block wins over RAM and RAM wins over the EEPROM. Any address that none of them claims selects external memory.
- R10: For every address, exactly one of `sel_reg`, `sel_ram`, `sel_eep` and `sel_ext` is 1. The selects follow the address combinationally.
- R11: When `acc_sel` = 2'b01, `rdata` returns the current mapping register at any time. When `acc_sel` = 2'b10, it returns the configuration byte {page[3:0], 1, wdog_off, 1, effective EEPROM enable}. Any other `acc_sel` value returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Processor address |
| bus_we | input | 1 | Write strobe, 1 = write |
| wdata | input | 8 | Write data |
| acc_sel | input | 2 | Register access: 01 = mapping, 10 = configuration |
| cfg_ee_page | input | 4 | EEPROM page nibble |
| cfg_ee_en | input | 1 | EEPROM enable |
| cfg_single_chip | input | 1 | Single-chip mode, forces the EEPROM on |
| cfg_wdog_off | input | 1 | Watchdog-disable bit, only read back here |
| sel_reg | output | 1 | Register block select |
| sel_ram | output | 1 | RAM select |
| sel_eep | output | 1 | EEPROM select |
| sel_ext | output | 1 | External memory select |
| rdata | output | 8 | Read data |

## Verification
The decoder is first probed at the edge addresses of every region, both under the reset mapping and after a relocation that stacks the register block, RAM and the EEPROM in one 4 KB page. These probes separate an off-by-one limit from a wrong priority. Write attempts are placed at edge 63, at edge 64 and just after a successful write, which separates a correct window length and single-use lock from an open-ended one. A long run of random addresses with random configuration bits then checks the one-hot selects and the forced EEPROM enable against the reference model on every cycle.

// File: rtl/mm_pkg.sv
// Package: types shared by the memory map decoder.
// Assumes a 16-bit address space made of sixteen 4 KB pages.
package mm_pkg;
    typedef enum logic [1:0] {
        RGN_EXT = 2'd0,
        RGN_EEP = 2'd1,
        RGN_RAM = 2'd2,
        RGN_REG = 2'd3
    } region_e;

    typedef struct packed {
        logic [3:0] ram_pg;
        logic [3:0] reg_pg;
    } map_t;

    localparam int NUM_RGN = 4;
endpackage

// File: rtl/mm_map_reg.sv
// Mapping register with a write window that opens once after reset.
// Counts edges after reset up to WIN_CYCLES and saturates there.
// Accepts the first write that arrives while the window is open, then locks.
// Assumes CNT_W can hold WIN_CYCLES.
module mm_map_reg #(
    parameter int         WIN_CYCLES = 64,
    parameter int         CNT_W      = 7,
    parameter logic [7:0] RST_VAL    = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [7:0]    wdata,
    output mm_pkg::map_t  map_q,
    output logic          win_open,
    output logic          used_q
);
    localparam logic [CNT_W-1:0] WIN_LIM = CNT_W'(WIN_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             wr_ok;

    assign win_open = (cnt_q < WIN_LIM);
    assign wr_ok    = wr_req && win_open && !used_q;

    // Window counter: cleared by reset, saturates at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (win_open)
            cnt_q <= cnt_q + 1'b1;
    end

    // Single-use lock: set by the first accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            used_q <= 1'b0;
        else if (wr_ok)
            used_q <= 1'b1;
    end

    // Mapping storage: loads the reset value, then takes the accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            map_q <= mm_pkg::map_t'(RST_VAL);
        else if (wr_ok)
            map_q <= mm_pkg::map_t'(wdata);
    end
endmodule

// File: rtl/mm_region_dec.sv
// Region decoder: compares the address against each internal region and
// resolves overlaps by priority (register block, then RAM, then EEPROM).
// Assumes RAM_BYTES and REG_BYTES each fit within a 4 KB page.
module mm_region_dec #(
    parameter int RAM_BYTES = 1024,
    parameter int REG_BYTES = 96
) (
    input  logic [15:0]       addr,
    input  mm_pkg::map_t      map_q,
    input  logic [3:0]        ee_page,
    input  logic              ee_on,
    output mm_pkg::region_e   region
);
    localparam logic [12:0] RAM_LIM = 13'(RAM_BYTES);
    localparam logic [12:0] REG_LIM = 13'(REG_BYTES);

    logic [3:0]  pg;
    logic [12:0] off;
    logic        hit_reg, hit_ram, hit_eep;

    assign pg  = addr[15:12];
    assign off = {1'b0, addr[11:0]};

    // Hit detection per region.
    always_comb begin
        hit_reg = (pg == map_q.reg_pg) && (off < REG_LIM);
        hit_ram = (pg == map_q.ram_pg) && (off < RAM_LIM);
        hit_eep = ee_on && (pg == ee_page) && (addr[11:9] == 3'b111);
    end

    // Priority resolution into a single region code.
    always_comb begin
        if (hit_reg)
            region = mm_pkg::RGN_REG;
        else if (hit_ram)
            region = mm_pkg::RGN_RAM;
        else if (hit_eep)
            region = mm_pkg::RGN_EEP;
        else
            region = mm_pkg::RGN_EXT;
    end
endmodule

// File: rtl/mm_rd_mux.sv
// Read-back multiplexer for the mapping register and the configuration byte.
// Assumes acc_sel 01 selects the mapping and 10 selects the configuration.
module mm_rd_mux (
    input  logic [1:0] acc_sel,
    input  logic [7:0] map_bits,
    input  logic [3:0] ee_page,
    input  logic       wdog_off,
    input  logic       ee_on,
    output logic [7:0] rdata
);
    // Selects the read source; unused codes return zero.
    always_comb begin
        unique case (acc_sel)
            2'b01:   rdata = map_bits;
            2'b10:   rdata = {ee_page, 1'b1, wdog_off, 1'b1, ee_on};
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/memmap_decoder.sv
// Top level of the relocatable memory map decoder.
// Combines the one-shot mapping register, the region decoder and the read-back
// mux, and expands the region code into one-hot selects.
// Assumes the inputs are synchronous to clk.
module memmap_decoder #(
    parameter int         RAM_BYTES  = 1024,
    parameter int         REG_BYTES  = 96,
    parameter int         WIN_CYCLES = 64,
    parameter int         CNT_W      = 7,
    parameter logic [7:0] RST_VAL    = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic        bus_we,
    input  logic [7:0]  wdata,
    input  logic [1:0]  acc_sel,
    input  logic [3:0]  cfg_ee_page,
    input  logic        cfg_ee_en,
    input  logic        cfg_single_chip,
    input  logic        cfg_wdog_off,
    output logic        sel_reg,
    output logic        sel_ram,
    output logic        sel_eep,
    output logic        sel_ext,
    output logic [7:0]  rdata
);
    mm_pkg::map_t    map_q;
    mm_pkg::region_e region;
    logic [7:0]      map_bits;
    logic            win_open;
    logic            used_q;
    logic            ee_on;
    logic            map_wr;
    logic [mm_pkg::NUM_RGN-1:0] sel_vec;

    assign map_bits = map_q;
    assign ee_on    = cfg_ee_en || cfg_single_chip;
    assign map_wr   = bus_we && (acc_sel == 2'b01);

    mm_map_reg #(
        .WIN_CYCLES (WIN_CYCLES),
        .CNT_W      (CNT_W),
        .RST_VAL    (RST_VAL)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (map_wr),
        .wdata    (wdata),
        .map_q    (map_q),
        .win_open (win_open),
        .used_q   (used_q)
    );

    mm_region_dec #(
        .RAM_BYTES (RAM_BYTES),
        .REG_BYTES (REG_BYTES)
    ) u_dec (
        .addr    (addr),
        .map_q   (map_q),
        .ee_page (cfg_ee_page),
        .ee_on   (ee_on),
        .region  (region)
    );

    mm_rd_mux u_rd (
        .acc_sel  (acc_sel),
        .map_bits (map_bits),
        .ee_page  (cfg_ee_page),
        .wdog_off (cfg_wdog_off),
        .ee_on    (ee_on),
        .rdata    (rdata)
    );

    // One-hot expansion of the region code.
    for (genvar g = 0; g < mm_pkg::NUM_RGN; g++) begin : g_sel
        assign sel_vec[g] = (region == mm_pkg::region_e'(g));
    end

    assign sel_ext = sel_vec[0];
    assign sel_eep = sel_vec[1];
    assign sel_ram = sel_vec[2];
    assign sel_reg = sel_vec[3];
endmodule

// File: rtl/mm_checker.sv
// Property checker for memmap_decoder, attached by bind.
module mm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        bus_we,
    input logic [7:0]  wdata,
    input logic [1:0]  acc_sel,
    input logic [3:0]  cfg_ee_page,
    input logic        cfg_single_chip,
    input logic        sel_reg,
    input logic        sel_ram,
    input logic        sel_eep,
    input logic        sel_ext,
    input logic [7:0]  map_bits,
    input logic        win_open,
    input logic        used_q
);
    // R10
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_reg, sel_ram, sel_eep, sel_ext}) == 1);

    // R3
    accept_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && acc_sel == 2'b01 && win_open && !used_q) |=> (map_bits == $past(wdata)));

    // R4
    closed_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> $stable(map_bits));

    // R5
    single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_q |=> $stable(map_bits));

    // R9
    reg_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:12] == map_bits[3:0] && addr[11:0] == 12'h000) |-> sel_reg);

    // R8
    forced_eep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_single_chip && addr[15:12] == cfg_ee_page && addr[11:9] == 3'b111
         && !sel_reg && !sel_ram) |-> sel_eep);
endmodule

bind memmap_decoder mm_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .addr            (addr),
    .bus_we          (bus_we),
    .wdata           (wdata),
    .acc_sel         (acc_sel),
    .cfg_ee_page     (cfg_ee_page),
    .cfg_single_chip (cfg_single_chip),
    .sel_reg         (sel_reg),
    .sel_ram         (sel_ram),
    .sel_eep         (sel_eep),
    .sel_ext         (sel_ext),
    .map_bits        (map_bits),
    .win_open        (win_open),
    .used_q          (used_q)
);

// File: tb/sim_memmap_decoder.sv
module sim_memmap_decoder;
    localparam int RAM_B = 3712;
    localparam int REG_B = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  wdata = '0;
    logic [1:0]  acc_sel = '0;
    logic [3:0]  cfg_ee_page = 4'hF;
    logic        cfg_ee_en = 1'b1;
    logic        cfg_single_chip = 1'b0;
    logic        cfg_wdog_off = 1'b0;
    logic        sel_reg, sel_ram, sel_eep, sel_ext;
    logic [7:0]  rdata;

    int vectors = 0;
    int errors  = 0;

    // reference state
    int ref_map = 1;
    int ref_cnt = 0;
    bit ref_used = 0;

    memmap_decoder #(.RAM_BYTES(RAM_B), .REG_BYTES(REG_B)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .bus_we(bus_we), .wdata(wdata),
        .acc_sel(acc_sel), .cfg_ee_page(cfg_ee_page), .cfg_ee_en(cfg_ee_en),
        .cfg_single_chip(cfg_single_chip), .cfg_wdog_off(cfg_wdog_off),
        .sel_reg(sel_reg), .sel_ram(sel_ram), .sel_eep(sel_eep), .sel_ext(sel_ext),
        .rdata(rdata));

    always #4 clk = ~clk;

    // reference model state update
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_map  = 1;
            ref_cnt  = 0;
            ref_used = 0;
        end else begin
            if (bus_we && acc_sel == 2'b01 && ref_cnt < 64 && !ref_used) begin
                ref_map  = int'(wdata);
                ref_used = 1;
            end
            if (ref_cnt < 64) ref_cnt = ref_cnt + 1;
        end
    end

    function automatic int exp_region(); // 3 reg, 2 ram, 1 eep, 0 ext
        int pg, off;
        bit eon;
        pg  = int'(addr) / 4096;
        off = int'(addr) % 4096;
        eon = cfg_ee_en || cfg_single_chip;
        if (pg == (ref_map % 16) && off < REG_B) return 3;
        if (pg == (ref_map / 16) && off < RAM_B) return 2;
        if (eon && pg == int'(cfg_ee_page) && off >= 'hE00) return 1;
        return 0;
    endfunction

    function automatic int exp_rdata();
        bit eon;
        eon = cfg_ee_en || cfg_single_chip;
        if (acc_sel == 2'b01) return ref_map;
        if (acc_sel == 2'b10) return int'(cfg_ee_page) * 16 + 8 + (cfg_wdog_off ? 4 : 0) + 2 + (eon ? 1 : 0);
        return 0;
    endfunction

    task automatic compare(input string tag);
        int er, ar, ed;
        er = exp_region();
        ed = exp_rdata();
        ar = sel_reg ? 3 : sel_ram ? 2 : sel_eep ? 1 : 0;
        vectors++;
        if ((int'(sel_reg) + int'(sel_ram) + int'(sel_eep) + int'(sel_ext)) != 1) begin
            errors++;
            $display("FAIL %s/R10 addr=%h selects=%b%b%b%b expected one-hot",
                     tag, addr, sel_reg, sel_ram, sel_eep, sel_ext);
        end else if (ar != er) begin
            errors++;
            $display("FAIL %s addr=%h region actual=%0d expected=%0d", tag, addr, ar, er);
        end
        if (int'(rdata) != ed) begin
            errors++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, ed[7:0]);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic we, input logic [1:0] acc,
                        input logic [7:0] d, input string tag);
        @(negedge clk);
        addr = a; bus_we = we; acc_sel = acc; wdata = d;
        #1 compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rand_run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            addr = 16'($urandom);
            acc_sel = 2'($urandom);
            bus_we = 1'b0;
            cfg_ee_page = 4'($urandom);
            cfg_ee_en = 1'($urandom);
            cfg_single_chip = 1'($urandom);
            cfg_wdog_off = 1'($urandom);
            #1 compare("R10");
        end
        cfg_ee_page = 4'hF; cfg_ee_en = 1'b1; cfg_single_chip = 1'b0; cfg_wdog_off = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset mapping
        step(16'h0000, 0, 2'b01, 8'h00, "R1");
        step(16'h1000, 0, 2'b00, 8'h00, "R1");
        // R2 region limits
        step(16'h0E7F, 0, 2'b00, 8'h00, "R2");
        step(16'h0E80, 0, 2'b00, 8'h00, "R2");
        step(16'h105F, 0, 2'b00, 8'h00, "R2");
        step(16'h1060, 0, 2'b00, 8'h00, "R2");
        // R6 EEPROM window
        step(16'hFE00, 0, 2'b00, 8'h00, "R6");
        step(16'hFFFF, 0, 2'b00, 8'h00, "R6");
        step(16'hFDFF, 0, 2'b00, 8'h00, "R6");
        // R7 disabled EEPROM
        cfg_ee_en = 1'b0;
        step(16'hFE00, 0, 2'b10, 8'h00, "R7");
        // R8 single-chip forces enable
        cfg_single_chip = 1'b1;
        step(16'hFE00, 0, 2'b10, 8'h00, "R8");
        cfg_single_chip = 1'b0; cfg_ee_en = 1'b1; cfg_wdog_off = 1'b1;
        // R11 readback
        step(16'h2000, 0, 2'b10, 8'h00, "R11");
        step(16'h2000, 0, 2'b11, 8'h00, "R11");
        cfg_wdog_off = 1'b0;
        // R3 write inside window, then stacked overlap page
        step(16'h0000, 1, 2'b01, 8'h33, "R3");
        step(16'h0000, 0, 2'b01, 8'h00, "R3");
        cfg_ee_page = 4'h3;
        // R9 priority
        step(16'h3000, 0, 2'b00, 8'h00, "R9");
        step(16'h305F, 0, 2'b00, 8'h00, "R9");
        step(16'h3060, 0, 2'b00, 8'h00, "R9");
        step(16'h3E00, 0, 2'b00, 8'h00, "R9");
        step(16'h3E80, 0, 2'b00, 8'h00, "R9");
        step(16'h0000, 0, 2'b00, 8'h00, "R9");
        // R5 second write ignored
        step(16'h0000, 1, 2'b01, 8'h45, "R5");
        step(16'h0000, 0, 2'b01, 8'h00, "R5");
        step(16'h4000, 0, 2'b00, 8'h00, "R5");
        cfg_ee_page = 4'hF;
        rand_run(300);

        // R4 write at edge 64 ignored
        do_reset();
        while (ref_cnt < 64) step(16'h0000, 0, 2'b00, 8'h00, "R4");
        step(16'h0000, 1, 2'b01, 8'h77, "R4");
        step(16'h7000, 0, 2'b01, 8'h00, "R4");
        step(16'h1000, 0, 2'b01, 8'h00, "R4");

        // R3 write at edge 63 accepted
        do_reset();
        while (ref_cnt < 63) step(16'h0000, 0, 2'b00, 8'h00, "R3");
        step(16'h0000, 1, 2'b01, 8'h52, "R3");
        step(16'h2000, 0, 2'b01, 8'h00, "R3");
        step(16'h5000, 0, 2'b00, 8'h00, "R3");
        rand_run(300);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule